// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a lookup misses. It takes one missing 32-bit virtual address at a time and reads the page tables in physical memory. Bits 31:22 of the address select an entry in the root table. Bits 21:12 select an entry in the second-level table that the root entry names. Bits 11:0 are the page offset and play no part in the walk. Every entry is 4 bytes wide, so each index is multiplied by four to form a byte address. The walker's own reads go straight to physical memory and are never translated.

The root table address comes from a base input that system software reloads whenever the running user changes. The walker samples it when it accepts a miss. An entry uses bit 0 as its residency flag, bits 3:1 as read, write and user permissions, and bits 31:12 as a physical frame number. Bits 31:12 hold a disk block number instead when the flag is clear. If either entry on the path is not resident, the walker stops at once and reports a page fault for the original address. It never reaches for secondary storage. A successful walk delivers the page number, the frame number and the combined permissions for the buffer to install.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: The first read of a walk goes to `root_base + 4*vaddr[31:22]`. `root_base` is sampled in the cycle the miss is accepted, and later changes to it do not alter the walk.
- R3: When the root entry has bit 0 set, the second read goes to `{root_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: Once `mem_req_valid` rises, it and `mem_req_addr` stay constant until the cycle in which `mem_req_ready` is 1.
- R5: A root entry with bit 0 clear ends the walk after one read. The walker then raises `fault_valid` with `fault_vaddr` equal to the missing address and `fault_level` 0.
- R6: A second-level entry with bit 0 clear raises `fault_valid` with `fault_level` 1 and `fault_vaddr` equal to the missing address.
- R7: A walk that finds both entries resident raises `refill_valid` with the following fields:
  - `refill_vpn` = vaddr[31:12]
  - `refill_ppn` = second-level entry bits 31:12
  - `refill_perm` = root bits 3:1 AND second-level bits 3:1 (bit 2 read, bit 1 write, bit 0 user)
- R8: `miss_ready` is 0 from the cycle after a miss is accepted until the result has been delivered. A `miss_valid` presented in that window is ignored.
- R9: Responses may take any number of cycles. `mem_rsp_valid` is ignored while no read is outstanding, and no result appears before the last needed response.
- R10: `refill_valid` and `fault_valid` are never high together. Each result lasts exactly one cycle, and `miss_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and accepts a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Physical address of the current user's root table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| refill_valid | output | 1 | One-cycle pulse: translation ready to install |
| refill_vpn | output | 20 | Virtual page number of the translation |
| refill_ppn | output | 20 | Physical frame number of the translation |
| refill_perm | output | 3 | Combined read/write/user permissions |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_level | output | 1 | 0 = root entry absent, 1 = second-level entry absent |

## Verification
A corrupted walk state shows up at the memory port within one cycle. Symptoms include a request raised while the walker should be waiting, a request address that moves before acceptance, or a second read after an absent root entry. Wrong latched data, such as a stale base, index or entry, shows up as a wrong read address on the next request. Otherwise it appears in the result fields in the single cycle the result is valid. The directed walks vary the handshake and response latencies so that state held across stalls is exercised.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_valid,
  output logic        miss_ready,
  input  logic [31:0] miss_vaddr,
  input  logic [31:0] root_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        refill_valid,
  output logic [19:0] refill_vpn,
  output logic [19:0] refill_ppn,
  output logic [2:0]  refill_perm,
  output logic        fault_valid,
  output logic [31:0] fault_vaddr,
  output logic        fault_level
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } state_t;

  state_t      state;
  logic [31:0] va_q;
  logic [31:0] base_q;
  logic [19:0] tbl_q;
  logic [2:0]  perm1_q;
  logic [19:0] ppn_q;
  logic [2:0]  perm2_q;
  logic        lvl_q;
  logic        unused_bits;

  assign unused_bits = ^mem_rsp_data[11:4];

  assign miss_ready    = state == ST_IDLE;
  assign mem_req_valid = state == ST_L1_REQ || state == ST_L2_REQ;
  assign mem_req_addr  = (state == ST_L2_REQ) ? {tbl_q, va_q[21:12], 2'b00}
                                               : base_q + {20'd0, va_q[31:22], 2'b00};
  assign refill_valid  = state == ST_DONE;
  assign refill_vpn    = va_q[31:12];
  assign refill_ppn    = ppn_q;
  assign refill_perm   = perm1_q & perm2_q;
  assign fault_valid   = state == ST_FAULT;
  assign fault_vaddr   = va_q;
  assign fault_level   = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      perm1_q <= '0;
      ppn_q   <= '0;
      perm2_q <= '0;
      lvl_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (miss_valid) begin
          va_q   <= miss_vaddr;
          base_q <= root_base;
          state  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          tbl_q   <= mem_rsp_data[31:12];
          perm1_q <= mem_rsp_data[3:1];
          lvl_q   <= 1'b0;
          state   <= mem_rsp_data[0] ? ST_L2_REQ : ST_FAULT;
        end
        ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          ppn_q   <= mem_rsp_data[31:12];
          perm2_q <= mem_rsp_data[3:1];
          lvl_q   <= 1'b1;
          state   <= mem_rsp_data[0] ? ST_DONE : ST_FAULT;
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));

  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid || fault_valid |=> miss_ready && !refill_valid && !fault_valid);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !miss_ready);

  assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid);

  assert_root_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !fault_level |-> $past(!mem_rsp_data[0]));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic        miss_ready;
  logic [31:0] miss_vaddr;
  logic [31:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [19:0] refill_ppn;
  logic [2:0]  refill_perm;
  logic        fault_valid;
  logic [31:0] fault_vaddr;
  logic        fault_level;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vaddr(miss_vaddr),
    .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_perm(refill_perm),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_level(fault_level)
  );

  bit [31:0] pmem [bit [31:0]];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(string name, logic [31:0] va, logic [31:0] base, logic [31:0] base_after,
                      int rdy_lat, int rsp_lat, bit stray, bit extra_miss,
                      bit exp_fault, logic exp_lvl, int exp_reads,
                      logic [19:0] exp_ppn, logic [2:0] exp_perm);
    logic [31:0] exp_addr;
    logic [31:0] data;
    int reads = 0;
    bit done = 0;
    @(negedge clk);
    root_base = base; miss_vaddr = va; miss_valid = 1'b1;
    check_eq({name, " R8 idle ready"}, miss_ready, 1);
    @(negedge clk);
    miss_valid = 1'b0; root_base = base_after;
    check_eq({name, " R8 busy after accept"}, miss_ready, 0);
    if (extra_miss) begin miss_valid = 1'b1; miss_vaddr = 32'hDEAD_BEEF; end
    if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF; end
    exp_addr = base + {20'd0, va[31:22], 2'b00};
    while (!done && reads < 3) begin
      check_eq({name, reads == 0 ? " R2 l1 req" : " R3 l2 req"}, mem_req_valid, 1);
      check_eq({name, reads == 0 ? " R2 l1 addr" : " R3 l2 addr"}, mem_req_addr, exp_addr);
      for (int i = 0; i < rdy_lat; i++) begin
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check_eq({name, " R4 hold valid"}, mem_req_valid, 1);
        check_eq({name, " R4 hold addr"}, mem_req_addr, exp_addr);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      reads++;
      check_eq({name, " R9 no req while waiting"}, mem_req_valid, 0);
      for (int i = 0; i < rsp_lat; i++) begin
        @(negedge clk);
        check_eq({name, " R9 no early result"}, {30'd0, refill_valid, fault_valid}, 0);
        check_eq({name, " R8 busy in wait"}, miss_ready, 0);
      end
      data = pmem.exists(exp_addr) ? pmem[exp_addr] : 32'h0;
      mem_rsp_valid = 1'b1; mem_rsp_data = data;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (refill_valid || fault_valid || reads == 2) done = 1;
      else exp_addr = {data[31:12], va[21:12], 2'b00};
    end
    miss_valid = 1'b0;
    check_eq({name, exp_fault ? (exp_lvl ? " R6 reads" : " R5 reads") : " R7 reads"}, reads, exp_reads);
    check_eq({name, " R10 fault_valid"}, fault_valid, exp_fault);
    check_eq({name, " R10 refill_valid"}, refill_valid, !exp_fault);
    if (exp_fault) begin
      check_eq({name, exp_lvl ? " R6 vaddr" : " R5 vaddr"}, fault_vaddr, va);
      check_eq({name, exp_lvl ? " R6 level" : " R5 level"}, fault_level, exp_lvl);
    end else begin
      check_eq({name, " R7 vpn"}, refill_vpn, va[31:12]);
      check_eq({name, " R7 ppn"}, refill_ppn, exp_ppn);
      check_eq({name, " R7 perm"}, refill_perm, exp_perm);
    end
    @(negedge clk);
    check_eq({name, " R10 pulse ends"}, {30'd0, refill_valid, fault_valid}, 0);
    check_eq({name, " R10 ready again"}, miss_ready, 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs", {28'd0, miss_ready, mem_req_valid, refill_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 after release", {28'd0, miss_ready, mem_req_valid, refill_valid, fault_valid}, 32'h8);
  endtask

  initial begin
    miss_valid = 0; miss_vaddr = 0; root_base = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    pmem[32'h0001_0004] = 32'h0002_000F;
    pmem[32'h0002_000C] = 32'h0ABC_D00B;
    pmem[32'h0002_0014] = 32'h1234_5006;
    pmem[32'h0003_0004] = 32'h0004_0005;
    pmem[32'h0004_000C] = 32'h0000_700F;
    pmem[32'h0005_0FFC] = 32'h0006_0003;
    pmem[32'h0006_0FFC] = 32'hFFFF_F00F;
    test_reset();
    walk("basic R7", 32'h0040_3123, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 0, 0, 0, 2, 20'h0ABCD, 3'b101);
    walk("root absent R5", 32'hFFC0_0000, 32'h0001_0000, 32'h0001_0000, 1, 2, 0, 0, 1, 0, 1, 20'h0, 3'b0);
    walk("leaf absent R6", 32'h0040_5000, 32'h0001_0000, 32'h0001_0000, 2, 1, 0, 0, 1, 1, 2, 20'h0, 3'b0);
    walk("user switch R2", 32'h0040_3123, 32'h0003_0000, 32'h0001_0000, 1, 1, 0, 0, 0, 0, 2, 20'h00007, 3'b010);
    walk("slow stray R9", 32'h0040_3123, 32'h0001_0000, 32'h0001_0000, 5, 7, 1, 1, 0, 0, 2, 20'h0ABCD, 3'b101);
    walk("top index R3", 32'hFFFF_FFFF, 32'h0005_0000, 32'h0005_0000, 0, 3, 1, 0, 0, 0, 2, 20'hFFFFF, 3'b001);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule